// File: doc/BRIEF.md
# Memory-Mapped Configuration Window Decoder

This block turns a configuration request (segment, bus, device/function, register offset, access size) into a single access on one of two downstream ports. It holds a small table of configuration windows. Each window names a segment, a bus range and a base address. The block looks up the window that covers the request, forms the physical address of the target device's 4 KiB page, and issues a memory-style access carrying lane-aligned byte enables and write data.

When redirection is enabled, an offset in the low 256 bytes goes to a legacy configuration port instead of the memory window. That port carries an address word in the classic enable/bus/device/register layout. The block rejects a request if a field is out of range, if the access size is unsupported, if the access would straddle a dword, or if no window covers the request. A rejected read returns all ones. A rejected request never reaches either downstream port.

The block remembers the last device page it opened. It pulses an update strobe only when a memory access targets a different page, so that a mapping stage further on can skip redundant remaps.

Top module: `cfg_window_decoder`

## Requirements
- R1: A request with bus above 255, device/function above 255, or register offset above 4095 is rejected with `rsp_cause` = 1. A rejected read returns `rsp_rdata` = 32'hFFFF_FFFF. A rejected write returns 0.
- R2: A memory access issues with `mem_addr` = base | bus<<20 | devfn<<12 | offset[11:0].
- R3: Windows are searched from index 0 upward. The first valid window with a matching segment and start ≤ bus ≤ end supplies the base.
- R4: If nothing matches, and window 0 is the only valid window and has segment 0 with start and end bus both 0, then its base is used for any segment and bus. Once a second window is valid, this fallback no longer applies.
- R5: If no base is found, the request is rejected with `rsp_cause` = 3. Neither `mem_valid` nor `leg_valid` is raised.
- R6: When `leg_redirect_en` is 1 and the offset is below 256, the access goes to the legacy port, whether or not any window matches. Its `leg_addr` = {1'b1, 7'b0, bus[7:0], devfn[7:0], offset[7:2], 2'b00}. Otherwise the offset uses the memory window.
- R7: `req_size` codes 1, 2 and 4 select byte, word and dword. Byte enables are 4'b0001<<off, 4'b0011<<off and 4'b1111, where off = offset[1:0]. Write data is shifted left by 8·off. A word at off 3, a dword at off ≠ 0, or any other size code is rejected with `rsp_cause` = 2.
- R8: `map_base` holds the last opened device page (base | bus<<20 | devfn<<12). `map_update` pulses, together with `mem_valid`, only when a memory access targets a page different from that one, or when it is the first memory access after reset.
- R9: Outputs for a request appear one cycle after it is sampled, together with a one-cycle `rsp_valid`. A read's `rsp_rdata` is the downstream read word shifted right by 8·off and masked to the access size.
- R10: A table write takes effect from the next cycle. A window written with its valid bit clear takes part in neither the search nor the fallback.
- R11: Rejection causes rank range (1) over size/alignment (2) over missing window (3). A request that is not rejected reports cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_valid | input | 1 | Valid bit for the written entry |
| tbl_seg | input | SEG_W | Segment of the written entry |
| tbl_start | input | 8 | First bus of the written entry |
| tbl_end | input | 8 | Last bus of the written entry |
| tbl_base | input | 32 | Base address of the written entry |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| leg_redirect_en | input | 1 | Send offsets below 256 to the legacy port |
| req_seg | input | SEG_W | Request segment |
| req_bus | input | BUS_IN_W | Request bus number |
| req_devfn | input | FN_IN_W | Request device/function |
| req_reg | input | REG_IN_W | Request register byte offset |
| req_size | input | 3 | Access size code (1, 2, 4) |
| req_wdata | input | 32 | Write data, right-justified |
| mem_valid | output | 1 | Memory-window access strobe |
| mem_addr | output | 32 | Memory-window byte address |
| leg_valid | output | 1 | Legacy-port access strobe |
| leg_addr | output | 32 | Legacy-port address word |
| dn_write | output | 1 | Direction of the issued access |
| dn_be | output | 4 | Byte enables of the issued access |
| dn_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word from the memory port (same cycle) |
| leg_rdata | input | 32 | Read word from the legacy port (same cycle) |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Request rejected |
| rsp_cause | output | 2 | 0 ok, 1 range, 2 size/alignment, 3 no window |
| rsp_rdata | output | 32 | Read result |
| map_update | output | 1 | Device page changed |
| map_base | output | 32 | Last opened device page |

## Verification
The assertions assume that the downstream ports answer a read combinationally in the cycle the access issues. They also assume that `req_valid` is sampled only on rising edges, with its fields stable around the edge. The bench drives all inputs on falling edges and drives the read-data inputs as fixed functions of the issued address. It programs only window bases that are 256 MiB aligned, so the OR in R2 and the bench's sum agree. The random stimulus keeps buses in a small range, so windows hit often. Only a small share of requests carry out-of-range fields or illegal size codes, so every rejection class is reached without drowning out the successful paths.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int CW_AW     = 32;
  localparam int CW_SIZE_W = 3;

  typedef enum logic [1:0] {
    CW_OK    = 2'd0,
    CW_RANGE = 2'd1,
    CW_ALIGN = 2'd2,
    CW_NOWIN = 2'd3
  } cw_cause_e;

  // Device page: base with bus in [27:20] and devfn in [19:12]
  function automatic logic [CW_AW-1:0] cw_dev_window(input logic [CW_AW-1:0] base,
                                                     input logic [7:0] bus,
                                                     input logic [7:0] devfn);
    return base | {4'b0000, bus, devfn, 12'h000};
  endfunction

  function automatic logic [3:0] cw_lane_mask(input logic [CW_SIZE_W-1:0] size,
                                              input logic [1:0] off);
    case (size)
      3'd1:    return 4'b0001 << off;
      3'd2:    return 4'b0011 << off;
      3'd4:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic cw_lane_fit(input logic [CW_SIZE_W-1:0] size,
                                       input logic [1:0] off);
    case (size)
      3'd1:    return 1'b1;
      3'd2:    return off != 2'd3;
      3'd4:    return off == 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CW_AW-1:0] cw_legacy_addr(input logic [7:0] bus,
                                                      input logic [7:0] devfn,
                                                      input logic [7:0] reg8);
    return {1'b1, 7'b0, bus, devfn, reg8[7:2], 2'b00};
  endfunction

  function automatic logic [31:0] cw_extract(input logic [31:0] raw,
                                             input logic [CW_SIZE_W-1:0] size,
                                             input logic [1:0] off);
    logic [31:0] sh;
    sh = raw >> {off, 3'b000};
    case (size)
      3'd1:    return {24'h0, sh[7:0]};
      3'd2:    return {16'h0, sh[15:0]};
      default: return sh;
    endcase
  endfunction

endpackage

// File: rtl/cfgwin_table.sv
module cfgwin_table #(
  parameter int N_ENT = 4,
  parameter int SEG_W = 16,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [IDX_W-1:0]            widx,
  input  logic                        wvalid,
  input  logic [SEG_W-1:0]            wseg,
  input  logic [7:0]                  wstart,
  input  logic [7:0]                  wend,
  input  logic [cfgwin_pkg::CW_AW-1:0] wbase,
  output logic [N_ENT-1:0]            ent_valid,
  output logic [SEG_W-1:0]            ent_seg   [N_ENT],
  output logic [7:0]                  ent_start [N_ENT],
  output logic [7:0]                  ent_end   [N_ENT],
  output logic [cfgwin_pkg::CW_AW-1:0] ent_base  [N_ENT]
);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic sel;
    assign sel = wr && (widx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[e] <= 1'b0;
        ent_seg[e]   <= '0;
        ent_start[e] <= '0;
        ent_end[e]   <= '0;
        ent_base[e]  <= '0;
      end else if (sel) begin
        ent_valid[e] <= wvalid;
        ent_seg[e]   <= wseg;
        ent_start[e] <= wstart;
        ent_end[e]   <= wend;
        ent_base[e]  <= wbase;
      end
    end
  end

endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match #(
  parameter int N_ENT = 4,
  parameter int SEG_W = 16,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0]            ent_valid,
  input  logic [SEG_W-1:0]            ent_seg   [N_ENT],
  input  logic [7:0]                  ent_start [N_ENT],
  input  logic [7:0]                  ent_end   [N_ENT],
  input  logic [cfgwin_pkg::CW_AW-1:0] ent_base  [N_ENT],
  input  logic [SEG_W-1:0]            req_seg,
  input  logic [7:0]                  req_bus,
  output logic                        found,
  output logic                        via_fallback,
  output logic [IDX_W-1:0]            hit_idx,
  output logic [cfgwin_pkg::CW_AW-1:0] win_base
);

  logic [N_ENT-1:0]            hit_vec;
  logic                        any_hit;
  logic                        lone_zero;
  logic [cfgwin_pkg::CW_AW-1:0] pri_base;

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    assign hit_vec[e] = ent_valid[e] && (ent_seg[e] == req_seg) &&
                        (ent_start[e] <= req_bus) && (req_bus <= ent_end[e]);
  end

  // Lowest index wins: scan downward so the last write is the smallest hit
  always_comb begin
    hit_idx  = '0;
    pri_base = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_idx  = IDX_W'(i);
        pri_base = ent_base[i];
      end
    end
  end

  assign any_hit   = |hit_vec;
  assign lone_zero = (ent_valid == N_ENT'(1)) && (ent_seg[0] == '0) &&
                     (ent_start[0] == 8'd0) && (ent_end[0] == 8'd0);

  assign via_fallback = !any_hit && lone_zero;
  assign found        = any_hit || lone_zero;
  assign win_base     = any_hit ? pri_base : ent_base[0];

endmodule

// File: rtl/cfgwin_lanes.sv
module cfgwin_lanes (
  input  logic [cfgwin_pkg::CW_SIZE_W-1:0] size,
  input  logic [1:0]                       off,
  input  logic [31:0]                      wdata,
  output logic [3:0]                       be,
  output logic                             fit,
  output logic [31:0]                      wdata_lane
);
  import cfgwin_pkg::*;

  assign be         = cw_lane_mask(size, off);
  assign fit        = cw_lane_fit(size, off);
  assign wdata_lane = wdata << {off, 3'b000};

endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder #(
  parameter int N_ENT    = 4,
  parameter int SEG_W    = 16,
  parameter int BUS_IN_W = 9,
  parameter int FN_IN_W  = 9,
  parameter int REG_IN_W = 13,
  localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tbl_wr,
  input  logic [IDX_W-1:0]    tbl_idx,
  input  logic                tbl_valid,
  input  logic [SEG_W-1:0]    tbl_seg,
  input  logic [7:0]          tbl_start,
  input  logic [7:0]          tbl_end,
  input  logic [31:0]         tbl_base,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                leg_redirect_en,
  input  logic [SEG_W-1:0]    req_seg,
  input  logic [BUS_IN_W-1:0] req_bus,
  input  logic [FN_IN_W-1:0]  req_devfn,
  input  logic [REG_IN_W-1:0] req_reg,
  input  logic [2:0]          req_size,
  input  logic [31:0]         req_wdata,
  output logic                mem_valid,
  output logic [31:0]         mem_addr,
  output logic                leg_valid,
  output logic [31:0]         leg_addr,
  output logic                dn_write,
  output logic [3:0]          dn_be,
  output logic [31:0]         dn_wdata,
  input  logic [31:0]         mem_rdata,
  input  logic [31:0]         leg_rdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [1:0]          rsp_cause,
  output logic [31:0]         rsp_rdata,
  output logic                map_update,
  output logic [31:0]         map_base
);
  import cfgwin_pkg::*;

  localparam int PAGE_BYTES = 4096;
  localparam int LOW_BYTES  = 256;
  localparam int ID_LIMIT   = 255;

  // table
  logic [N_ENT-1:0] ent_valid;
  logic [SEG_W-1:0] ent_seg   [N_ENT];
  logic [7:0]       ent_start [N_ENT];
  logic [7:0]       ent_end   [N_ENT];
  logic [31:0]      ent_base  [N_ENT];

  cfgwin_table #(.N_ENT(N_ENT), .SEG_W(SEG_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr(tbl_wr), .widx(tbl_idx), .wvalid(tbl_valid),
    .wseg(tbl_seg), .wstart(tbl_start), .wend(tbl_end), .wbase(tbl_base),
    .ent_valid(ent_valid), .ent_seg(ent_seg), .ent_start(ent_start),
    .ent_end(ent_end), .ent_base(ent_base)
  );

  // lookup
  logic [7:0]       bus8, devfn8;
  logic [11:0]      reg12;
  logic             win_found, win_fallback;
  logic [IDX_W-1:0] win_idx;
  logic [31:0]      win_base;

  assign bus8   = req_bus[7:0];
  assign devfn8 = req_devfn[7:0];
  assign reg12  = req_reg[11:0];

  cfgwin_match #(.N_ENT(N_ENT), .SEG_W(SEG_W)) u_match (
    .ent_valid(ent_valid), .ent_seg(ent_seg), .ent_start(ent_start),
    .ent_end(ent_end), .ent_base(ent_base), .req_seg(req_seg), .req_bus(bus8),
    .found(win_found), .via_fallback(win_fallback), .hit_idx(win_idx),
    .win_base(win_base)
  );

  // lanes
  logic [3:0]  lane_be;
  logic        lane_fit;
  logic [31:0] lane_wdata;

  cfgwin_lanes u_lanes (
    .size(req_size), .off(req_reg[1:0]), .wdata(req_wdata),
    .be(lane_be), .fit(lane_fit), .wdata_lane(lane_wdata)
  );

  // request-cycle decision, brought out as named events
  logic      range_bad, to_legacy;
  cw_cause_e cause;
  logic      issue_mem_now, issue_leg_now, reject_now, dev_change;
  logic [31:0] dev_window;
  logic [31:0] last_dev;
  logic        last_valid;

  assign range_bad = (req_bus > BUS_IN_W'(ID_LIMIT)) ||
                     (req_devfn > FN_IN_W'(ID_LIMIT)) ||
                     (req_reg > REG_IN_W'(PAGE_BYTES - 1));
  assign to_legacy = leg_redirect_en && (req_reg < REG_IN_W'(LOW_BYTES));

  always_comb begin
    if (range_bad)                    cause = CW_RANGE;
    else if (!lane_fit)               cause = CW_ALIGN;
    else if (!to_legacy && !win_found) cause = CW_NOWIN;
    else                              cause = CW_OK;
  end

  assign dev_window    = cw_dev_window(win_base, bus8, devfn8);
  assign issue_mem_now = req_valid && (cause == CW_OK) && !to_legacy;
  assign issue_leg_now = req_valid && (cause == CW_OK) && to_legacy;
  assign reject_now    = req_valid && (cause != CW_OK);
  assign dev_change    = !last_valid || (dev_window != last_dev);

  // issue stage
  logic        rsp_valid_q, err_q, mem_valid_q, leg_valid_q, wr_q, map_update_q;
  cw_cause_e   cause_q;
  logic [2:0]  size_q;
  logic [1:0]  off_q;
  logic [3:0]  be_q;
  logic [31:0] wdata_q, mem_addr_q, leg_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      err_q        <= 1'b0;
      mem_valid_q  <= 1'b0;
      leg_valid_q  <= 1'b0;
      map_update_q <= 1'b0;
      wr_q         <= 1'b0;
      cause_q      <= CW_OK;
      size_q       <= '0;
      off_q        <= '0;
      be_q         <= '0;
      wdata_q      <= '0;
      mem_addr_q   <= '0;
      leg_addr_q   <= '0;
      last_dev     <= '0;
      last_valid   <= 1'b0;
    end else begin
      rsp_valid_q  <= req_valid;
      err_q        <= reject_now;
      mem_valid_q  <= issue_mem_now;
      leg_valid_q  <= issue_leg_now;
      map_update_q <= issue_mem_now && dev_change;
      if (req_valid) begin
        cause_q    <= cause;
        wr_q       <= req_write;
        size_q     <= req_size;
        off_q      <= req_reg[1:0];
        be_q       <= (cause == CW_OK) ? lane_be : 4'b0000;
        wdata_q    <= (cause == CW_OK) ? lane_wdata : 32'h0;
        mem_addr_q <= dev_window | {20'h0, reg12};
        leg_addr_q <= cw_legacy_addr(bus8, devfn8, reg12[7:0]);
      end
      if (issue_mem_now && dev_change) begin
        last_dev   <= dev_window;
        last_valid <= 1'b1;
      end
    end
  end

  always_comb begin
    rsp_rdata = 32'h0;
    if (rsp_valid_q && !wr_q) begin
      if (err_q)            rsp_rdata = 32'hFFFF_FFFF;
      else if (leg_valid_q) rsp_rdata = cw_extract(leg_rdata, size_q, off_q);
      else                  rsp_rdata = cw_extract(mem_rdata, size_q, off_q);
    end
  end

  assign mem_valid  = mem_valid_q;
  assign mem_addr   = mem_addr_q;
  assign leg_valid  = leg_valid_q;
  assign leg_addr   = leg_addr_q;
  assign dn_write   = wr_q;
  assign dn_be      = be_q;
  assign dn_wdata   = wdata_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_err    = err_q;
  assign rsp_cause  = cause_q;
  assign map_update = map_update_q;
  assign map_base   = last_dev;

endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker #(
  parameter int BUS_IN_W = 9,
  parameter int FN_IN_W  = 9,
  parameter int REG_IN_W = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [BUS_IN_W-1:0] req_bus,
  input logic [FN_IN_W-1:0]  req_devfn,
  input logic [REG_IN_W-1:0] req_reg,
  input logic [2:0]          req_size,
  input logic                reject_now,
  input logic                mem_valid,
  input logic [31:0]         mem_addr,
  input logic                leg_valid,
  input logic [31:0]         leg_addr,
  input logic                dn_write,
  input logic [3:0]          dn_be,
  input logic                rsp_valid,
  input logic                rsp_err,
  input logic [1:0]          rsp_cause,
  input logic [31:0]         rsp_rdata,
  input logic                map_update,
  input logic [31:0]         map_base
);

  // R1
  range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ((req_bus > 255) || (req_devfn > 255) || (req_reg > 4095))
    |=> rsp_err && (rsp_cause == 2'd1) && !mem_valid && !leg_valid);

  // R1
  ones_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err && !dn_write |-> rsp_rdata == 32'hFFFF_FFFF);

  // R5
  reject_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_now |=> !mem_valid && !leg_valid);

  // R5
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({mem_valid, leg_valid, rsp_err}) == 1);

  // R7
  dword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_bus <= 255) && (req_devfn <= 255) && (req_reg <= 4095) &&
    (req_size == 3'd4) && (req_reg[1:0] != 2'd0) |=> rsp_err && (rsp_cause == 2'd2));

  // R7
  lanes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid || leg_valid |-> dn_be != 4'b0000);

  // R6
  legacy_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leg_valid |-> leg_addr[31] && (leg_addr[1:0] == 2'b00));

  // R8
  page_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_base != $past(map_base)) |-> map_update);

  // R8
  update_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_update |-> mem_valid && (mem_addr[31:12] == map_base[31:12]));

  // R9
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !mem_valid && !leg_valid);

endmodule

bind cfg_window_decoder cfgwin_checker #(
  .BUS_IN_W(BUS_IN_W), .FN_IN_W(FN_IN_W), .REG_IN_W(REG_IN_W)
) u_cfgwin_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
  .req_devfn(req_devfn), .req_reg(req_reg), .req_size(req_size),
  .reject_now(reject_now), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .leg_valid(leg_valid), .leg_addr(leg_addr), .dn_write(dn_write), .dn_be(dn_be),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_cause(rsp_cause),
  .rsp_rdata(rsp_rdata), .map_update(map_update), .map_base(map_base)
);

// File: tb/test_cfg_window_decoder.sv
module test_cfg_window_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr = 1'b0;
  logic [1:0]  tbl_idx = '0;
  logic        tbl_valid = 1'b0;
  logic [15:0] tbl_seg = '0;
  logic [7:0]  tbl_start = '0, tbl_end = '0;
  logic [31:0] tbl_base = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, leg_redirect_en = 1'b0;
  logic [15:0] req_seg = '0;
  logic [8:0]  req_bus = '0, req_devfn = '0;
  logic [12:0] req_reg = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        mem_valid, leg_valid, dn_write, rsp_valid, rsp_err, map_update;
  logic [31:0] mem_addr, leg_addr, dn_wdata, rsp_rdata, map_base;
  logic [31:0] mem_rdata, leg_rdata;
  logic [3:0]  dn_be;
  logic [1:0]  rsp_cause;

  always #2 clk = ~clk;

  assign mem_rdata = mem_addr ^ 32'h5A5A_C3C3;
  assign leg_rdata = {leg_addr[7:0], leg_addr[31:8]};

  cfg_window_decoder i_cfg_window_decoder (
    .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
    .tbl_seg(tbl_seg), .tbl_start(tbl_start), .tbl_end(tbl_end), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_write(req_write), .leg_redirect_en(leg_redirect_en),
    .req_seg(req_seg), .req_bus(req_bus), .req_devfn(req_devfn), .req_reg(req_reg),
    .req_size(req_size), .req_wdata(req_wdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .leg_valid(leg_valid), .leg_addr(leg_addr), .dn_write(dn_write), .dn_be(dn_be),
    .dn_wdata(dn_wdata), .mem_rdata(mem_rdata), .leg_rdata(leg_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_cause(rsp_cause),
    .rsp_rdata(rsp_rdata), .map_update(map_update), .map_base(map_base)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model of the window table and the open page
  bit          m_v [4];
  int unsigned m_seg [4], m_lo [4], m_hi [4];
  logic [31:0] m_base [4];
  bit          m_open = 0;
  logic [31:0] m_page = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic prog(input int idx, input bit v, input int unsigned seg,
                      input int unsigned lo, input int unsigned hi, input logic [31:0] base);
    @(negedge clk);
    tbl_wr = 1; tbl_idx = 2'(idx); tbl_valid = v; tbl_seg = 16'(seg);
    tbl_start = 8'(lo); tbl_end = 8'(hi); tbl_base = base;
    @(negedge clk);
    tbl_wr = 0;
    m_v[idx] = v; m_seg[idx] = seg; m_lo[idx] = lo; m_hi[idx] = hi; m_base[idx] = base;
  endtask

  function automatic bit fits(input int unsigned sz, input int unsigned off);
    if (sz == 1) return 1;
    if (sz == 2) return off < 3;
    if (sz == 4) return off == 0;
    return 0;
  endfunction

  task automatic apply(input bit wr, input bit redir, input int unsigned seg,
                       input int unsigned bus, input int unsigned fn, input int unsigned rg,
                       input int unsigned sz, input logic [31:0] wd, input string tag);
    int unsigned off, cause, nval;
    bit legacy, found;
    logic [31:0] base, page, eaddr, elegacy, raw, erd, mask;
    logic [3:0] ebe;
    off = rg % 4;
    legacy = redir && (rg < 256);
    found = 0; base = 0;
    for (int i = 0; i < 4; i++)
      if (!found && m_v[i] && m_seg[i] == seg && m_lo[i] <= bus && bus <= m_hi[i]) begin
        found = 1; base = m_base[i];
      end
    nval = 0;
    for (int i = 0; i < 4; i++) nval += m_v[i];
    if (!found && nval == 1 && m_v[0] && m_seg[0] == 0 && m_lo[0] == 0 && m_hi[0] == 0) begin
      found = 1; base = m_base[0];
    end
    if (bus > 255 || fn > 255 || rg > 4095) cause = 1;
    else if (!fits(sz, off))                cause = 2;
    else if (!legacy && !found)             cause = 3;
    else                                    cause = 0;
    page    = base + bus * 32'h0010_0000 + fn * 32'h1000;
    eaddr   = page + rg;
    elegacy = 32'h8000_0000 + bus * 65536 + fn * 256 + (rg / 4) * 4;
    ebe     = (sz == 4) ? 4'hF : (sz == 2 ? 4'(3 << off) : 4'(1 << off));
    mask    = (sz == 1) ? 32'hFF : (sz == 2 ? 32'hFFFF : 32'hFFFF_FFFF);
    raw     = legacy ? {elegacy[7:0], elegacy[31:8]} : (eaddr ^ 32'h5A5A_C3C3);
    if (wr)              erd = 0;
    else if (cause != 0) erd = 32'hFFFF_FFFF;
    else                 erd = (raw >> (8 * off)) & mask;

    @(negedge clk);
    req_valid = 1; req_write = wr; leg_redirect_en = redir; req_seg = 16'(seg);
    req_bus = 9'(bus); req_devfn = 9'(fn); req_reg = 13'(rg); req_size = 3'(sz); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R9", "rsp_valid", 32'(rsp_valid), 1);
    chk(rsp_err === (cause != 0), tag, "rsp_err", 32'(rsp_err), 32'(cause != 0));
    chk(rsp_cause === 2'(cause), "R11", "rsp_cause", 32'(rsp_cause), cause);
    chk(mem_valid === (cause == 0 && !legacy), tag, "mem_valid", 32'(mem_valid), 32'(cause == 0 && !legacy));
    chk(leg_valid === (cause == 0 && legacy), "R6", "leg_valid", 32'(leg_valid), 32'(cause == 0 && legacy));
    chk(rsp_rdata === erd, "R9", "rsp_rdata", rsp_rdata, erd);
    if (cause == 0 && !legacy)
      chk(mem_addr === eaddr, "R2", "mem_addr", mem_addr, eaddr);
    if (cause == 0 && legacy)
      chk(leg_addr === elegacy, "R6", "leg_addr", leg_addr, elegacy);
    if (cause == 0) begin
      chk(dn_be === ebe, "R7", "dn_be", 32'(dn_be), 32'(ebe));
      if (wr) chk(dn_wdata === (wd << (8 * off)), "R7", "dn_wdata", dn_wdata, wd << (8 * off));
    end
    if (cause == 0 && !legacy) begin
      chk(map_update === (!m_open || page != m_page), "R8", "map_update",
          32'(map_update), 32'(!m_open || page != m_page));
      m_open = 1; m_page = page;
      chk(map_base === m_page, "R8", "map_base", map_base, m_page);
    end else begin
      chk(map_update === 1'b0, "R8", "map_update idle", 32'(map_update), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd6021));
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_seg[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_base[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(!rsp_valid && !mem_valid && !leg_valid, "R9", "reset outputs", 32'({rsp_valid, mem_valid, leg_valid}), 0);
    chk(map_base === 0 && !map_update, "R8", "reset map_base", map_base, 0);

    // R5: empty table, no window
    apply(0, 0, 0, 3, 8, 256, 4, 0, "R5");
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9", "idle after request", 32'(rsp_valid), 0);

    // R4: lone degenerate entry serves any segment and bus
    prog(0, 1, 0, 0, 0, 32'h3000_0000);
    apply(0, 0, 5, 7, 9, 12'h104, 4, 0, "R4");
    prog(3, 1, 9, 200, 210, 32'h5000_0000);
    apply(0, 0, 5, 7, 9, 12'h104, 4, 0, "R4");
    // R10: an invalid entry covering the bus is ignored, fallback returns
    prog(3, 0, 5, 0, 255, 32'h5000_0000);
    apply(0, 0, 5, 7, 9, 12'h104, 4, 0, "R10");

    // R3: overlap, lowest index wins
    prog(0, 0, 0, 0, 0, 0);
    prog(1, 1, 1, 0, 10, 32'hA000_0000);
    prog(2, 1, 1, 5, 20, 32'hB000_0000);
    apply(0, 0, 1, 7, 3, 12'h200, 4, 0, "R3");
    apply(0, 0, 1, 15, 3, 12'h200, 4, 0, "R3");
    apply(0, 0, 2, 7, 3, 12'h200, 4, 0, "R5");

    // R1: out-of-range fields, reads and a write
    apply(0, 0, 1, 256, 3, 12'h200, 4, 0, "R1");
    apply(0, 0, 1, 7, 300, 12'h200, 4, 0, "R1");
    apply(0, 0, 1, 7, 3, 4096, 4, 0, "R1");
    apply(1, 0, 1, 7, 3, 4100, 4, 32'h1234_5678, "R1");
    // R11: range outranks alignment
    apply(0, 0, 1, 400, 3, 4099, 4, 0, "R11");

    // R7: sizes and alignment
    apply(1, 0, 1, 7, 3, 12'h203, 2, 32'h0000_BEEF, "R7");
    apply(1, 0, 1, 7, 3, 12'h201, 2, 32'h0000_BEEF, "R7");
    apply(0, 0, 1, 7, 3, 12'h202, 4, 0, "R7");
    apply(0, 0, 1, 7, 3, 12'h200, 3, 0, "R7");
    apply(1, 0, 1, 7, 3, 12'h303, 1, 32'h0000_00C5, "R7");
    apply(0, 0, 1, 7, 3, 12'h302, 2, 0, "R7");

    // R6: redirect of low offsets
    apply(0, 1, 1, 7, 3, 12'h040, 4, 0, "R6");
    apply(0, 0, 1, 7, 3, 12'h040, 4, 0, "R6");
    apply(0, 1, 1, 7, 3, 12'h100, 4, 0, "R6");
    apply(1, 1, 3, 99, 17, 12'h013, 1, 32'h0000_0077, "R6");

    // R8: same page twice, then another function
    apply(0, 0, 1, 9, 40, 12'h400, 4, 0, "R8");
    apply(0, 0, 1, 9, 40, 12'h808, 4, 0, "R8");
    apply(0, 0, 1, 9, 41, 12'h808, 4, 0, "R8");

    // constrained random
    for (int blk = 0; blk < 12; blk++) begin
      for (int e = 0; e < 4; e++) begin
        int unsigned lo;
        lo = $urandom_range(0, 12);
        prog(e, $urandom_range(0, 3) != 0, $urandom_range(0, 2), lo,
             lo + $urandom_range(0, 8), {4'($urandom_range(0, 15)), 28'h0});
      end
      for (int k = 0; k < 50; k++) begin
        int unsigned bus, fn, rg, sz, pick;
        bus = ($urandom_range(0, 19) == 0) ? $urandom_range(256, 511) : $urandom_range(0, 24);
        fn  = ($urandom_range(0, 19) == 0) ? $urandom_range(256, 511) : $urandom_range(0, 255);
        rg  = ($urandom_range(0, 19) == 0) ? $urandom_range(4096, 8191) : $urandom_range(0, 4095);
        pick = $urandom_range(0, 7);
        sz = (pick < 3) ? 4 : (pick < 5 ? 2 : (pick < 7 ? 1 : $urandom_range(0, 7)));
        apply($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 2),
              bus, fn, rg, sz, $urandom, "R2");
      end
    end
    summary();
  end

endmodule